// File: doc/BRIEF.md
# Oscillator source switch controller

This block sequences a software-initiated change of the system clock source. Six source codes are supported: the internal fast RC, fast RC followed by the PLL, the primary crystal, the primary crystal followed by the PLL, a low-power crystal and an internal low-power RC. Four oscillator circuits and the PLL are modelled as enable outputs. Each oscillator returns a tick input, which is one pulse per cycle of that oscillator as seen in the system clock domain. The PLL returns a lock input.

Software owns one 16-bit control/status word. It selects a next source and raises a request bit. Each byte of the word accepts a write only after its own two-key unlock sequence. The controller first validates the request and aborts it if the request is redundant, if it is a direct PLL-to-PLL change or if the code is unknown. For a valid request it clears the status flags and enables the new oscillator. A crystal that was off must then finish its start-up count, and a PLL source must report lock. The controller then counts a settle window of new-source cycles and commits the change. At commit it turns off the old oscillator unless one of the keep rules holds.

A configuration input disables the whole function. While disabled, the current-source field follows the configured reset source and the request bit stays clear.

Top module: `osc_switch_ctrl`

## Requirements
- R1: Word layout: bits 14:12 current source, bits 10:8 next source, bit 5 PLL lock, bit 3 clock-fail flag, bit 1 low-power-crystal keep, bit 0 switch request; other bits read 0. After reset, current and next equal `cfg_rst_src` and the flag bits are 0. Source codes: 000 fast RC, 001 fast RC+PLL, 010 primary, 011 primary+PLL, 100 low-power crystal, 101 low-power RC. `osc_en` bit 0 fast RC, 1 primary, 2 low-power crystal, 3 low-power RC.
- R2: While `cfg_sw_n` is 1, the request bit reads 0, the current-source field reads `cfg_rst_src` and neither `clk_sel` nor the enables react to a written next source.
- R3: A write that includes the high byte updates the next-source field only if the two key writes just before it were 0x78 and then 0x9A. One key pair admits exactly one such write.
- R4: A write that includes the low byte updates bits 3, 1 and 0 only if the two key writes just before it were 0x46 and then 0x57. One key pair admits exactly one such write.
- R5: A request whose next source equals the current source clears the request bit. It leaves the current source, the enables and the fail flag unchanged.
- R6: A request between 001 and 011 in either direction aborts the same way, and so does a request for code 110 or 111.
- R7: A valid request clears the lock and fail bits one cycle after the request is seen.
- R8: A valid request enables the new oscillator. If the new source is a crystal (010, 011, 100) whose oscillator was off, the controller waits `OST_CYC` ticks of that oscillator before anything else.
- R9: A new source that uses the PLL enables the PLL and holds the switch until `pll_lock` is 1.
- R10: After readiness the controller counts `SETTLE_CYC` ticks of the new oscillator. It then sets current to next and clears the request bit. No commit happens without those ticks.
- R11: At commit the old oscillator is disabled, except when it is the same oscillator as the new one, when it is the low-power RC and `cfg_lprc_keep` is 1, or when it is the low-power crystal and bit 1 is set. The PLL is disabled when the new source does not use it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_sw_n | input | 1 | Switching disable when 1 (active-low enable) |
| cfg_rst_src | input | 3 | Configured reset source code |
| cfg_lprc_keep | input | 1 | Watchdog or fail monitor keeps the low-power RC on |
| key_we | input | 1 | Key write strobe |
| key_data | input | 8 | Key value |
| bus_we | input | 1 | Word write strobe |
| bus_be | input | 2 | Byte enables: bit 1 high byte, bit 0 low byte |
| bus_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Control/status word |
| osc_tick | input | 4 | Per-oscillator cycle pulses |
| pll_lock | input | 1 | PLL lock indication |
| osc_en | output | 4 | Oscillator enables |
| pll_en | output | 1 | PLL enable |
| clk_sel | output | 3 | Source code driving the system clock mux |

## Verification
The bench builds the controller with `OST_CYC` at 16 instead of 1024, so the start-up wait of a newly enabled crystal can be measured as a cycle window against the settle count in a short run. `SETTLE_CYC` keeps its value of 10, and the bench also withholds new-source ticks to show that the settle count follows the new clock and not the system clock. The unlock keys keep their defaults, and both wrong-key and key-reuse cases are driven.

// File: rtl/osc_sw_pkg.sv
package osc_sw_pkg;

    localparam logic [2:0] SRC_FRC     = 3'b000;
    localparam logic [2:0] SRC_FRC_PLL = 3'b001;
    localparam logic [2:0] SRC_PRI     = 3'b010;
    localparam logic [2:0] SRC_PRI_PLL = 3'b011;
    localparam logic [2:0] SRC_LPXT    = 3'b100;
    localparam logic [2:0] SRC_LPRC    = 3'b101;

    localparam int OSC_N = 4;
    localparam logic [1:0] OSC_FRC  = 2'd0;
    localparam logic [1:0] OSC_PRI  = 2'd1;
    localparam logic [1:0] OSC_LPXT = 2'd2;
    localparam logic [1:0] OSC_LPRC = 2'd3;

    typedef enum logic [1:0] {
        SW_IDLE,
        SW_STARTUP,
        SW_PLLWAIT,
        SW_SETTLE
    } sw_state_e;

    typedef struct packed {
        sw_state_e        st;
        logic [2:0]       cur;
        logic [2:0]       nosc;
        logic [2:0]       tgt;
        logic [2:0]       old;
        logic             oswen;
        logic             lock;
        logic             cf;
        logic             lpkeep;
        logic [OSC_N-1:0] en;
        logic             pll_en;
    } ctl_s;

    function automatic logic [1:0] phys_of(input logic [2:0] s);
        case (s)
            SRC_FRC, SRC_FRC_PLL: phys_of = OSC_FRC;
            SRC_PRI, SRC_PRI_PLL: phys_of = OSC_PRI;
            SRC_LPXT:             phys_of = OSC_LPXT;
            default:              phys_of = OSC_LPRC;
        endcase
    endfunction

    function automatic logic uses_pll(input logic [2:0] s);
        uses_pll = (s == SRC_FRC_PLL) || (s == SRC_PRI_PLL);
    endfunction

    function automatic logic is_crystal(input logic [2:0] s);
        is_crystal = (s == SRC_PRI) || (s == SRC_PRI_PLL) || (s == SRC_LPXT);
    endfunction

    function automatic logic known_code(input logic [2:0] s);
        known_code = (s <= SRC_LPRC);
    endfunction

endpackage

// File: rtl/osc_tick_cnt.sv
module osc_tick_cnt #(
    parameter int LIMIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    assign done = (cnt_q == LIM);

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (tick && !done)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R10 / R8: the count never runs past its limit
    p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr) |=> done);

endmodule

// File: rtl/osc_unlock_seq.sv
module osc_unlock_seq #(
    parameter logic [7:0] KEY_HI_A = 8'h78,
    parameter logic [7:0] KEY_HI_B = 8'h9A,
    parameter logic [7:0] KEY_LO_A = 8'h46,
    parameter logic [7:0] KEY_LO_B = 8'h57
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_we,
    input  logic [7:0] key_data,
    input  logic       hi_use,
    input  logic       lo_use,
    output logic       hi_ok,
    output logic       lo_ok
);
    typedef enum logic [1:0] {KS_NONE, KS_HI_A, KS_LO_A} key_stage_e;

    typedef struct packed {
        key_stage_e stage;
        logic       arm_hi;
        logic       arm_lo;
    } key_s;

    key_s d, q;
    logic hi_done, lo_done;

    assign hi_ok   = q.arm_hi;
    assign lo_ok   = q.arm_lo;
    assign hi_done = key_we && (q.stage == KS_HI_A) && (key_data == KEY_HI_B);
    assign lo_done = key_we && (q.stage == KS_LO_A) && (key_data == KEY_LO_B);

    always_comb begin
        d = q;
        if (hi_use) d.arm_hi = 1'b0;
        if (lo_use) d.arm_lo = 1'b0;
        if (key_we) begin
            d.stage = KS_NONE;
            if (hi_done)                    d.arm_hi = 1'b1;
            else if (lo_done)               d.arm_lo = 1'b1;
            else if (key_data == KEY_HI_A)  d.stage  = KS_HI_A;
            else if (key_data == KEY_LO_A)  d.stage  = KS_LO_A;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{stage: KS_NONE, arm_hi: 1'b0, arm_lo: 1'b0};
        else        q <= d;
    end

    // R3: one key pair admits one high-byte write
    p_hi_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_use && !hi_done) |=> !hi_ok);
    // R4: one key pair admits one low-byte write
    p_lo_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_use && !lo_done) |=> !lo_ok);

endmodule

// File: rtl/osc_switch_ctrl.sv
module osc_switch_ctrl
    import osc_sw_pkg::*;
#(
    parameter int         OST_CYC    = 1024,
    parameter int         SETTLE_CYC = 10,
    parameter logic [7:0] KEY_HI_A   = 8'h78,
    parameter logic [7:0] KEY_HI_B   = 8'h9A,
    parameter logic [7:0] KEY_LO_A   = 8'h46,
    parameter logic [7:0] KEY_LO_B   = 8'h57
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_sw_n,
    input  logic [2:0]  cfg_rst_src,
    input  logic        cfg_lprc_keep,
    input  logic        key_we,
    input  logic [7:0]  key_data,
    input  logic        bus_we,
    input  logic [1:0]  bus_be,
    input  logic [15:0] bus_wdata,
    output logic [15:0] reg_rdata,
    input  logic [3:0]  osc_tick,
    input  logic        pll_lock,
    output logic [3:0]  osc_en,
    output logic        pll_en,
    output logic [2:0]  clk_sel
);
    ctl_s d, q;

    logic hi_use, lo_use, hi_ok, lo_ok;
    logic new_tick, ost_done, settle_done;
    logic req_abort;
    logic [1:0] p_new, p_old;
    logic unused_wdata;

    assign hi_use       = bus_we && bus_be[1];
    assign lo_use       = bus_we && bus_be[0];
    assign new_tick     = osc_tick[phys_of(q.tgt)];
    assign unused_wdata = ^{bus_wdata[15:11], bus_wdata[7:4], bus_wdata[2]};

    osc_unlock_seq #(
        .KEY_HI_A(KEY_HI_A), .KEY_HI_B(KEY_HI_B),
        .KEY_LO_A(KEY_LO_A), .KEY_LO_B(KEY_LO_B)
    ) u_unlock (
        .clk(clk), .rst_n(rst_n),
        .key_we(key_we), .key_data(key_data),
        .hi_use(hi_use), .lo_use(lo_use),
        .hi_ok(hi_ok), .lo_ok(lo_ok)
    );

    osc_tick_cnt #(.LIMIT(OST_CYC)) u_ost (
        .clk(clk), .rst_n(rst_n),
        .clr(q.st != SW_STARTUP), .tick(new_tick), .done(ost_done)
    );

    osc_tick_cnt #(.LIMIT(SETTLE_CYC)) u_settle (
        .clk(clk), .rst_n(rst_n),
        .clr(q.st != SW_SETTLE), .tick(new_tick), .done(settle_done)
    );

    assign req_abort = (q.nosc == q.cur) || !known_code(q.nosc) ||
                       (uses_pll(q.nosc) && uses_pll(q.cur));
    assign p_new = phys_of(q.tgt);
    assign p_old = phys_of(q.old);

    always_comb begin
        d = q;
        d.lock = pll_lock && q.pll_en &&
                 uses_pll((q.st == SW_IDLE) ? q.cur : q.tgt);

        if (hi_use && hi_ok)
            d.nosc = bus_wdata[10:8];
        if (lo_use && lo_ok) begin
            d.cf     = bus_wdata[3];
            d.lpkeep = bus_wdata[1];
            if (q.st == SW_IDLE) d.oswen = bus_wdata[0];
        end

        case (q.st)
            SW_IDLE: begin
                if (q.oswen) begin
                    if (req_abort) begin
                        d.oswen = 1'b0;
                    end else begin
                        d.lock = 1'b0;
                        d.cf   = 1'b0;
                        d.tgt  = q.nosc;
                        d.old  = q.cur;
                        d.en[phys_of(q.nosc)] = 1'b1;
                        if (uses_pll(q.nosc)) d.pll_en = 1'b1;
                        if (is_crystal(q.nosc) && !q.en[phys_of(q.nosc)])
                            d.st = SW_STARTUP;
                        else if (uses_pll(q.nosc))
                            d.st = SW_PLLWAIT;
                        else
                            d.st = SW_SETTLE;
                    end
                end
            end
            SW_STARTUP: begin
                if (ost_done) d.st = uses_pll(q.tgt) ? SW_PLLWAIT : SW_SETTLE;
            end
            SW_PLLWAIT: begin
                if (pll_lock) d.st = SW_SETTLE;
            end
            default: begin
                if (settle_done) begin
                    d.st    = SW_IDLE;
                    d.cur   = q.tgt;
                    d.oswen = 1'b0;
                    if ((p_old != p_new) &&
                        !((p_old == OSC_LPRC) && cfg_lprc_keep) &&
                        !((p_old == OSC_LPXT) && q.lpkeep))
                        d.en[p_old] = 1'b0;
                    if (!uses_pll(q.tgt)) d.pll_en = 1'b0;
                end
            end
        endcase

        if (cfg_sw_n) begin
            d.st    = SW_IDLE;
            d.oswen = 1'b0;
            d.cur   = cfg_rst_src;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= SW_IDLE;
            q.cur    <= cfg_rst_src;
            q.nosc   <= cfg_rst_src;
            q.tgt    <= cfg_rst_src;
            q.old    <= cfg_rst_src;
            q.en     <= 4'b0001 << phys_of(cfg_rst_src);
            q.pll_en <= uses_pll(cfg_rst_src);
        end else begin
            q <= d;
        end
    end

    assign reg_rdata = {1'b0, q.cur, 1'b0, q.nosc, 2'b00, q.lock, 1'b0,
                        q.cf, 1'b0, q.lpkeep, q.oswen};
    assign osc_en    = q.en;
    assign pll_en    = q.pll_en;
    assign clk_sel   = q.cur;

    // R2: request bit cannot survive while switching is disabled
    p_disabled_no_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_sw_n |=> !q.oswen);
    // R5: redundant request clears without moving the current source
    p_redundant_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SW_IDLE && q.oswen && !cfg_sw_n && q.nosc == q.cur)
        |=> (!q.oswen && q.cur == $past(q.cur) && q.st == SW_IDLE));
    // R6: PLL-to-PLL request never starts a switch
    p_pll_pair_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SW_IDLE && q.oswen && !cfg_sw_n &&
         uses_pll(q.nosc) && uses_pll(q.cur)) |=> (q.st == SW_IDLE && !q.oswen));
    // R7: a started switch clears lock and fail bits
    p_start_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SW_IDLE && q.oswen && !cfg_sw_n && !req_abort)
        |=> (!q.cf && !q.lock));
    // R8: the target oscillator is enabled for the whole switch
    p_target_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != SW_IDLE) |-> q.en[phys_of(q.tgt)]);
    // R9: no progress without PLL lock
    p_pll_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SW_PLLWAIT && !pll_lock && !cfg_sw_n) |=> q.st == SW_PLLWAIT);
    // R10: commit copies the target and drops the request
    p_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SW_SETTLE && settle_done && !cfg_sw_n)
        |=> (q.cur == $past(q.tgt) && !q.oswen));

endmodule

// File: tb/tb_osc_switch_ctrl.sv
module tb_osc_switch_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int OST        = 16;
    localparam int SETTLE     = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_sw_n = 1'b0;
    logic [2:0]  cfg_rst_src = 3'b000;
    logic        cfg_lprc_keep = 1'b0;
    logic        key_we = 1'b0;
    logic [7:0]  key_data = '0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_be = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] reg_rdata;
    logic [3:0]  osc_tick = '0;
    logic        pll_lock = 1'b0;
    logic [3:0]  osc_en;
    logic        pll_en;
    logic [2:0]  clk_sel;
    logic [3:0]  tick_mask = 4'hF;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) osc_tick <= osc_en & tick_mask;

    osc_switch_ctrl #(.OST_CYC(OST), .SETTLE_CYC(SETTLE)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_sw_n(cfg_sw_n), .cfg_rst_src(cfg_rst_src),
        .cfg_lprc_keep(cfg_lprc_keep), .key_we(key_we), .key_data(key_data),
        .bus_we(bus_we), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .reg_rdata(reg_rdata), .osc_tick(osc_tick), .pll_lock(pll_lock),
        .osc_en(osc_en), .pll_en(pll_en), .clk_sel(clk_sel)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [2:0] src);
        @(negedge clk);
        cfg_rst_src = src;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic put_key(input logic [7:0] k);
        @(negedge clk);
        key_we = 1'b1; key_data = k;
        @(negedge clk);
        key_we = 1'b0;
    endtask

    task automatic put_word(input logic [1:0] be, input logic [15:0] w);
        @(negedge clk);
        bus_we = 1'b1; bus_be = be; bus_wdata = w;
        @(negedge clk);
        bus_we = 1'b0; bus_be = '0;
    endtask

    task automatic set_next(input logic [2:0] s);
        put_key(8'h78); put_key(8'h9A);
        put_word(2'b10, {5'b0, s, 8'h00});
    endtask

    task automatic write_low(input logic cf, input logic lpk, input logic req);
        put_key(8'h46); put_key(8'h57);
        put_word(2'b01, {12'h000, cf, 1'b0, lpk, req});
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (reg_rdata[0] && n < 400) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset_state;
        do_reset(3'b101);
        chk("R1 word after reset src 101", reg_rdata, 16'h5500);
        chk("R1 enables after reset src 101", osc_en, 4'b1000);
        do_reset(3'b000);
        chk("R1 word after reset src 000", reg_rdata, 16'h0000);
        chk("R1 enables after reset src 000", {pll_en, osc_en}, 5'b00001);
    endtask

    task automatic t_unlock;
        put_word(2'b10, 16'h0500);
        chk("R3 high write without keys ignored", reg_rdata[10:8], 3'd0);
        put_key(8'h78); put_key(8'h11);
        put_word(2'b10, 16'h0500);
        chk("R3 high write after wrong key ignored", reg_rdata[10:8], 3'd0);
        set_next(3'b101);
        chk("R3 high write after keys lands", reg_rdata[10:8], 3'd5);
        put_word(2'b10, 16'h0400);
        chk("R3 key pair reused is refused", reg_rdata[10:8], 3'd5);
        put_word(2'b01, 16'h0008);
        chk("R4 low write without keys ignored", reg_rdata[3], 1'b0);
        write_low(1'b1, 1'b0, 1'b0);
        chk("R4 low write after keys lands", reg_rdata[3], 1'b1);
        put_word(2'b01, 16'h0000);
        chk("R4 low key pair reused is refused", reg_rdata[3], 1'b1);
    endtask

    task automatic t_redundant;
        set_next(3'b000);
        write_low(1'b1, 1'b0, 1'b1);
        repeat (2) @(negedge clk);
        chk("R5 redundant request cleared", reg_rdata[0], 1'b0);
        chk("R5 current unchanged", clk_sel, 3'd0);
        chk("R5 enables unchanged", osc_en, 4'b0001);
        chk("R5 fail flag kept on abort", reg_rdata[3], 1'b1);
    endtask

    task automatic t_frc_to_lprc;
        int n;
        set_next(3'b101);
        write_low(1'b1, 1'b0, 1'b1);
        @(negedge clk);
        chk("R7 fail flag cleared at start", reg_rdata[3], 1'b0);
        chk("R8 new oscillator enabled", osc_en[3], 1'b1);
        wait_done(n);
        chk("R10 settle duration window", (n >= SETTLE - 2 && n <= SETTLE + 4), 1);
        chk("R10 current takes next", reg_rdata[14:12], 3'd5);
        chk("R11 old oscillator off", osc_en, 4'b1000);
    endtask

    task automatic t_lprc_to_pri;
        int n;
        cfg_lprc_keep = 1'b1;
        set_next(3'b010);
        write_low(1'b0, 1'b0, 1'b1);
        wait_done(n);
        chk("R8 start-up plus settle window", (n >= OST + SETTLE && n <= OST + SETTLE + 6), 1);
        chk("R10 current is primary", clk_sel, 3'd2);
        chk("R11 low-power RC kept by config", osc_en, 4'b1010);
    endtask

    task automatic t_pri_to_pripll;
        int n;
        pll_lock = 1'b0;
        set_next(3'b011);
        write_low(1'b0, 1'b0, 1'b1);
        repeat (40) @(negedge clk);
        chk("R9 held while PLL unlocked", reg_rdata[0], 1'b1);
        chk("R9 PLL enabled", pll_en, 1'b1);
        chk("R9 current unchanged while waiting", clk_sel, 3'd2);
        pll_lock = 1'b1;
        wait_done(n);
        chk("R9 commit after lock window", (n >= SETTLE && n <= SETTLE + 5), 1);
        @(negedge clk);
        chk("R1 lock bit reads 1 on PLL source", reg_rdata[5], 1'b1);
        chk("R11 same oscillator stays on", osc_en, 4'b1010);
    endtask

    task automatic t_pll_pair;
        set_next(3'b001);
        write_low(1'b0, 1'b0, 1'b1);
        repeat (2) @(negedge clk);
        chk("R6 PLL to PLL request aborted", reg_rdata[0], 1'b0);
        chk("R6 current stays primary+PLL", clk_sel, 3'd3);
        set_next(3'b111);
        write_low(1'b0, 1'b0, 1'b1);
        repeat (2) @(negedge clk);
        chk("R6 unknown code aborted", {reg_rdata[0], clk_sel}, {1'b0, 3'd3});
    endtask

    task automatic t_pll_to_lpxt;
        int n;
        set_next(3'b100);
        write_low(1'b0, 1'b1, 1'b1);
        @(negedge clk);
        chk("R7 lock bit cleared at start", reg_rdata[5], 1'b0);
        wait_done(n);
        chk("R8 crystal start-up window", (n >= OST + SETTLE - 1 && n <= OST + SETTLE + 6), 1);
        chk("R11 primary and PLL off, LPRC kept", {pll_en, osc_en}, 5'b01100);
    endtask

    task automatic t_lpxt_to_frc;
        int n;
        set_next(3'b000);
        write_low(1'b0, 1'b1, 1'b1);
        wait_done(n);
        chk("R10 current is fast RC", clk_sel, 3'd0);
        chk("R11 low-power crystal kept by bit 1", osc_en, 4'b1101);
    endtask

    task automatic t_tick_withheld;
        int n;
        tick_mask = 4'b0111;
        set_next(3'b101);
        write_low(1'b0, 1'b1, 1'b1);
        repeat (30) @(negedge clk);
        chk("R10 no commit without new-source ticks", {reg_rdata[0], clk_sel}, {1'b1, 3'd0});
        tick_mask = 4'hF;
        wait_done(n);
        chk("R10 commit once ticks return", clk_sel, 3'd5);
        chk("R11 fast RC off, others kept", osc_en, 4'b1100);
    endtask

    task automatic t_disabled;
        cfg_sw_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2 current field shows reset source", reg_rdata[14:12], 3'd0);
        set_next(3'b010);
        write_low(1'b0, 1'b1, 1'b1);
        repeat (20) @(negedge clk);
        chk("R2 request bit held at 0", reg_rdata[0], 1'b0);
        chk("R2 next source has no effect", clk_sel, 3'd0);
        chk("R2 enables untouched", osc_en, 4'b1100);
    endtask

    initial begin
        t_reset_state();
        t_unlock();
        t_redundant();
        t_frc_to_lprc();
        t_lprc_to_pri();
        t_pri_to_pripll();
        t_pll_pair();
        t_pll_to_lpxt();
        t_lpxt_to_frc();
        t_tick_withheld();
        t_disabled();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule